// File: doc/BRIEF.md
# Split-Immediate Register File

This block is a register file of thirty-two 32-bit entries. It has two combinational read ports, one write port for ordinary results, and a separate port for immediate writes. Instructions are only 32 bits wide, so a full 32-bit constant cannot be carried by a single instruction. Software therefore builds the constant in two steps, each carrying a 16-bit immediate.

The low step writes the 16-bit immediate into the bottom half of the register and copies its bit 15 into all of the top half. The high step writes the immediate into the top half and keeps the bottom half as it was. The low step must come first. If the high step comes first, the low step then overwrites the upper half with sign bits, and the final constant is wrong.

Top module: `split_imm_regfile`

## Requirements
- R1: After reset, every register reads as 0x00000000.
- R2: When `res_we` is high, `res_data` is written to register `res_addr` at the clock edge.
- R3: When `imm_we` is high and `imm_hi` is 0 (low step), the register gets {16 copies of `imm_val[15]`, `imm_val`}.
- R4: When `imm_we` is high and `imm_hi` is 1 (high step), bits 31:16 of the register become `imm_val` and bits 15:0 keep their previous value.
- R5: Register 0x87654321, then a low step with 0xFABC, then a high step with 0x1234, reads 0xFFFFFABC and then 0x1234FABC.
- R6: Register 0x87654321, then a high step with 0x1234, then a low step with 0xFABC, reads 0x12344321 and then 0xFFFFFABC.
- R7: When both write ports target the same register in the same cycle, the immediate write is stored and the result write is dropped.
- R8: Both read ports return the value held before the current clock edge. A write appears on a read port only after that edge; there is no same-cycle bypass.
- R9: The two read ports are independent. Each returns the register selected by its own address, and a write to one register leaves all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd0_addr | input | 5 | Read port 0 address |
| rd0_data | output | 32 | Read port 0 data |
| rd1_addr | input | 5 | Read port 1 address |
| rd1_data | output | 32 | Read port 1 data |
| res_we | input | 1 | Result write enable |
| res_addr | input | 5 | Result write address |
| res_data | input | 32 | Result write data |
| imm_we | input | 1 | Immediate write enable |
| imm_hi | input | 1 | 0 selects the low step, 1 selects the high step |
| imm_addr | input | 5 | Immediate write address |
| imm_val | input | 16 | Immediate value |

## Verification
A corrupted register shows up only when that register is read, and always one clock after the write that caused it. Reading after every write exposes the error in that same cycle.

Certain faults leave a characteristic pattern in the read data:
- A lost merge on the high step shows as a wrong bottom half.
- A missing sign extension on the low step shows as zeros, not ones, in the top half.
- Wrong write priority shows as the result data surviving a collision with an immediate write.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int unsigned NREG  = 32;
    localparam int unsigned XLEN  = 32;
    localparam int unsigned HALF  = XLEN / 2;
    localparam int unsigned AW    = $clog2(NREG);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [AW-1:0]   ridx_t;
    typedef logic [HALF-1:0] half_t;

    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t val;
    } wr_t;
endpackage

// File: rtl/srf_imm_merge.sv
module srf_imm_merge
    import srf_pkg::*;
(
    input  logic  hi_sel,
    input  half_t imm,
    input  word_t cur,
    output word_t nxt
);
    always_comb begin
        if (hi_sel) nxt = {imm, cur[HALF-1:0]};
        else        nxt = {{HALF{imm[HALF-1]}}, imm};
    end
endmodule

// File: rtl/srf_wsel.sv
module srf_wsel
    import srf_pkg::*;
(
    input  wr_t res_w,
    input  wr_t imm_w,
    input  ridx_t slot,
    output logic  hit,
    output word_t val
);
    always_comb begin
        hit = 1'b0;
        val = '0;
        if (imm_w.en && imm_w.idx == slot) begin
            hit = 1'b1;
            val = imm_w.val;
        end else if (res_w.en && res_w.idx == slot) begin
            hit = 1'b1;
            val = res_w.val;
        end
    end
endmodule

// File: rtl/split_imm_regfile.sv
module split_imm_regfile
    import srf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  rd0_addr,
    output logic [31:0] rd0_data,
    input  logic [4:0]  rd1_addr,
    output logic [31:0] rd1_data,
    input  logic        res_we,
    input  logic [4:0]  res_addr,
    input  logic [31:0] res_data,
    input  logic        imm_we,
    input  logic        imm_hi,
    input  logic [4:0]  imm_addr,
    input  logic [15:0] imm_val
);
    typedef struct packed {
        word_t [NREG-1:0] regs;
    } state_t;

    state_t st_d, st_q;
    word_t  imm_cur, imm_word;
    wr_t    res_w, imm_w;
    logic   [NREG-1:0] hit;
    word_t  [NREG-1:0] wval;

    assign imm_cur = st_q.regs[imm_addr];

    srf_imm_merge u_merge (
        .hi_sel(imm_hi),
        .imm   (imm_val),
        .cur   (imm_cur),
        .nxt   (imm_word)
    );

    assign res_w = '{en: res_we, idx: res_addr, val: res_data};
    assign imm_w = '{en: imm_we, idx: imm_addr, val: imm_word};

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        srf_wsel u_wsel (
            .res_w(res_w),
            .imm_w(imm_w),
            .slot (ridx_t'(g)),
            .hit  (hit[g]),
            .val  (wval[g])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) st_d.regs[i] = wval[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd0_data = st_q.regs[rd0_addr];
    assign rd1_data = st_q.regs[rd1_addr];
endmodule

// File: rtl/split_imm_regfile_chk.sv
module split_imm_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  rd0_addr,
    input logic [31:0] rd0_data,
    input logic [4:0]  rd1_addr,
    input logic [31:0] rd1_data,
    input logic        res_we,
    input logic [4:0]  res_addr,
    input logic [31:0] res_data,
    input logic        imm_we,
    input logic        imm_hi,
    input logic [4:0]  imm_addr,
    input logic [15:0] imm_val
);
    // R2
    assert_res_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && !(imm_we && imm_addr == res_addr) && rd0_addr == res_addr)
        |=> (!$stable(rd0_addr) || rd0_data == $past(res_data)));
    // R3
    assert_lo_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_we && !imm_hi && rd0_addr == imm_addr)
        |=> (!$stable(rd0_addr) || rd0_data == {{16{$past(imm_val[15])}}, $past(imm_val)}));
    // R4
    assert_hi_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_we && imm_hi && rd0_addr == imm_addr)
        |=> (!$stable(rd0_addr) || rd0_data == {$past(imm_val), $past(rd0_data[15:0])}));
    // R7
    assert_imm_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_we && res_we && imm_addr == res_addr && !imm_hi && rd1_addr == imm_addr)
        |=> (!$stable(rd1_addr) || rd1_data == {{16{$past(imm_val[15])}}, $past(imm_val)}));
    // R9
    assert_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(res_we && res_addr == rd1_addr) && !(imm_we && imm_addr == rd1_addr))
        |=> (!$stable(rd1_addr) || $stable(rd1_data)));
endmodule

bind split_imm_regfile split_imm_regfile_chk u_chk (.*);

// File: tb/test_split_imm_regfile.sv
module test_split_imm_regfile;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  rd0_addr = 0, rd1_addr = 0, res_addr = 0, imm_addr = 0;
    logic [31:0] rd0_data, rd1_data, res_data = 0;
    logic        res_we = 0, imm_we = 0, imm_hi = 0;
    logic [15:0] imm_val = 0;

    int total = 0, bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    split_imm_regfile i_split_imm_regfile (.*);

    task automatic expect0(input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: pops one expectation and compares with rd0 away from the edge
    task automatic monitor0();
        logic [31:0] e;
        string t;
        #5;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (rd0_data !== e) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", t, rd0_data, e);
        end
    endtask

    task automatic chk1(input logic [31:0] e, input string t);
        total++;
        if (rd1_data !== e) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", t, rd1_data, e);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        res_we = 0;
        imm_we = 0;
    endtask

    task automatic wres(input logic [4:0] a, input logic [31:0] d);
        res_we = 1; res_addr = a; res_data = d;
        step();
    endtask

    task automatic wimm(input logic [4:0] a, input logic hi, input logic [15:0] v);
        imm_we = 1; imm_addr = a; imm_hi = hi; imm_val = v;
        step();
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #35 rst_n = 1;
        @(negedge clk);
        for (int i = 0; i < 32; i += 7) begin
            rd0_addr = 5'(i);
            expect0(32'h0, "R1 reset");
            monitor0();
        end
        rd0_addr = 31;
        expect0(32'h0, "R1 reset r31");
        monitor0();

        rd0_addr = 3;
        wres(3, 32'hDEADBEEF);
        expect0(32'hDEADBEEF, "R2 result write");
        monitor0();

        rd0_addr = 4;
        wimm(4, 0, 16'h7123);
        expect0(32'h00007123, "R3 low positive");
        monitor0();
        wimm(4, 0, 16'h8001);
        expect0(32'hFFFF8001, "R3 low negative");
        monitor0();

        wimm(4, 1, 16'hABCD);
        expect0(32'hABCD8001, "R4 high merge");
        monitor0();

        rd0_addr = 5;
        wres(5, 32'h87654321);
        wimm(5, 0, 16'hFABC);
        expect0(32'hFFFFFABC, "R5 low first");
        monitor0();
        wimm(5, 1, 16'h1234);
        expect0(32'h1234FABC, "R5 final");
        monitor0();

        rd0_addr = 6;
        wres(6, 32'h87654321);
        wimm(6, 1, 16'h1234);
        expect0(32'h12344321, "R6 high first");
        monitor0();
        wimm(6, 0, 16'hFABC);
        expect0(32'hFFFFFABC, "R6 wrong final");
        monitor0();

        rd0_addr = 7;
        res_we = 1; res_addr = 7; res_data = 32'h55555555;
        imm_we = 1; imm_addr = 7; imm_hi = 0; imm_val = 16'h0042;
        step();
        expect0(32'h00000042, "R7 imm wins");
        monitor0();

        rd0_addr = 8;
        #2;
        res_we = 1; res_addr = 8; res_data = 32'hCAFEF00D;
        #1;
        total++;
        if (rd0_data !== 32'h0) begin
            bad++;
            $display("FAIL R8 bypass act=%h exp=%h", rd0_data, 32'h0);
        end
        step();
        expect0(32'hCAFEF00D, "R8 after edge");
        monitor0();

        rd1_addr = 3;
        #1;
        chk1(32'hDEADBEEF, "R9 port1 r3 intact");
        rd0_addr = 5;
        expect0(32'h1234FABC, "R9 port0 r5 intact");
        monitor0();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule